// File: doc/BRIEF.md
# Microprogrammed Superstate Sequencer with Shallow History

This block steps through a statechart that has been compiled into microcode. A micro-memory holds one instruction per basic state. On every clock the sequencer reads the instruction at its program counter, tests the instruction's condition slots against event flags and counter comparisons, and picks the next address. Each instruction also carries two action fields that go to external counter and output logic. One instance runs one or more superstates that are never active at the same time. Concurrent regions are built by instantiating several copies that share the same events, counters and action consumers.

The eight lowest target addresses are not real memory locations. Each one names a superstate, and the sequencer replaces it with the address stored in that superstate's history register. When the sequencer leaves a superstate whose history flag is set, it saves the current address into that superstate's history register, so a later entry resumes where it left off. A superstate without the flag always re-enters at its configured start address.

All contents (micro-memory, initial history addresses and history flags) arrive as a byte stream with a valid/ready handshake. The sequencer stays idle until the last byte has been taken. It does not accept configuration again until the next reset. Back-pressure is simple: `cfg_ready_o` is high from reset until the final byte is accepted and low after that. A byte moves only on a clock edge where both valid and ready are high, and the sender must hold the byte stable until then.

Top module: `sq_sequencer`

## Requirements
- R1: After reset, and until the last configuration byte is accepted, `run_o` is 0, `cfg_ready_o` is 1 and `act_o` is all zero.
- R2: On the edge that accepts the last configuration byte, `run_o` rises, `ss_o` becomes 0 and `pc_o` becomes the configured history address of superstate 0.
- R3: In a condition slot with comparison code 0, the reference-select bit chooses between the constant true (1) and event flag `evt_i[idx]` (0). A set invert bit negates the slot's result.
- R4: Comparison codes 1, 2 and 3 test counter `cnt_i[idx]` against reference `ref_i[rsel]` for less, equal and greater (unsigned).
- R5: A slot with its chain bit set is ANDed with the next slot. The group takes the target of its last slot.
- R6: Slots (or chained groups) are scanned from slot 0 upward and the first true one decides the next address. If none is true, `pc_o` holds.
- R7: A winning target of 8 or above is loaded into `pc_o` on the next edge, and `ss_o` does not change.
- R8: A winning target t below 8 loads `pc_o` with history register t on the next edge and sets `ss_o` to t.
- R9: On such a transition, if the history flag of the current superstate is set, the current `pc_o` is written into that superstate's history register. If the flag is clear, the register keeps its configured value.
- R10: While running, `act_o` shows the action fields of the instruction at `pc_o`, with action 0 in bits 5:0 and action 1 in bits 11:6.
- R11: Configuration is 8 history bytes (superstates 0..7, low 6 bits used), then one flag byte (bit i is superstate i), then 64 words of 11 bytes each, least significant byte first. Within a word, slot i sits at bits 14i+13..14i, with fields target 5:0, chain 6, rsel 7, invert 8, comparison 10:9 and idx 13:11. Actions sit at bits 81:70. Bytes offered after loading are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_valid_i | input | 1 | Configuration byte valid |
| cfg_ready_o | output | 1 | Configuration byte accepted when high |
| cfg_data_i | input | 8 | Configuration byte |
| evt_i | input | 8 | Event flags |
| cnt_i | input | 16 | Two 8-bit counter values, counter 0 in bits 7:0 |
| ref_i | input | 16 | Two 8-bit reference values, reference 0 in bits 7:0 |
| run_o | output | 1 | Configuration complete, sequencer stepping |
| pc_o | output | 6 | Current micro-address |
| ss_o | output | 3 | Index of the active superstate |
| act_o | output | 12 | Action fields of the current instruction |

## Verification
A corrupted history register stays hidden while its superstate is active. It shows up only on the cycle after a later re-entry, when `pc_o` lands at the wrong address and `act_o` changes to match. The stimulus therefore leaves a superstate that has history, passes through others, and returns to it. A fault in slot priority or in chaining shows one cycle after the deciding input pattern, as the wrong next address. Every step checks `pc_o`, `ss_o` and `act_o` together, one edge after its inputs are applied.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_AW    = 6;
  localparam int SQ_IDX_W = 3;
  localparam int SQ_NEV   = 2 ** SQ_IDX_W;

  typedef enum logic [1:0] {
    CMP_EVT = 2'd0,
    CMP_LT  = 2'd1,
    CMP_EQ  = 2'd2,
    CMP_GT  = 2'd3
  } cmp_sel_e;

  typedef struct packed {
    logic [SQ_IDX_W-1:0] idx;
    cmp_sel_e            cmp;
    logic                inv;
    logic                rsel;
    logic                chain;
    logic [SQ_AW-1:0]    tgt;
  } cond_t;

  localparam int SQ_COND_W = $bits(cond_t);
endpackage

// File: rtl/sq_cfg_loader.sv
module sq_cfg_loader #(
  parameter int NSS   = 8,
  parameter int AW    = 6,
  parameter int DEPTH = 64,
  parameter int IW    = 82
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  output logic                   ready_o,
  input  logic [7:0]             data_i,
  output logic                   done_o,
  output logic                   hist_we_o,
  output logic [$clog2(NSS)-1:0] hist_idx_o,
  output logic [AW-1:0]          hist_val_o,
  output logic                   flag_we_o,
  output logic [NSS-1:0]         flag_val_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [IW-1:0]          mem_wdata_o
);
  localparam int WB    = (IW + 7) / 8;
  localparam int SRW   = (WB - 1) * 8;
  localparam int TOTAL = NSS + 1 + DEPTH * WB;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int BW    = $clog2(WB);
  localparam int IXW   = $clog2(NSS);

  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bsel_q;
  logic [AW-1:0]  addr_q;
  logic [SRW-1:0] sr_q;
  logic           done_q;
  logic           take, in_hist, in_flag, in_mem;
  logic [WB*8-1:0] full_word;

  assign ready_o = !done_q;
  assign done_o  = done_q;
  assign take    = valid_i && !done_q;
  assign in_hist = cnt_q < CW'(NSS);
  assign in_flag = cnt_q == CW'(NSS);
  assign in_mem  = !in_hist && !in_flag;

  assign full_word   = {data_i, sr_q};
  assign hist_we_o   = take && in_hist;
  assign hist_idx_o  = cnt_q[IXW-1:0];
  assign hist_val_o  = data_i[AW-1:0];
  assign flag_we_o   = take && in_flag;
  assign flag_val_o  = data_i[NSS-1:0];
  assign mem_we_o    = take && in_mem && (bsel_q == BW'(WB - 1));
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = full_word[IW-1:0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bsel_q <= '0;
      addr_q <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(TOTAL - 1)) done_q <= 1'b1;
      if (in_mem) begin
        sr_q <= {data_i, sr_q[SRW-1:8]};
        if (bsel_q == BW'(WB - 1)) begin
          bsel_q <= '0;
          addr_q <= addr_q + 1'b1;
        end else begin
          bsel_q <= bsel_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sq_cond_eval.sv
module sq_cond_eval import sq_pkg::*; #(
  parameter int NSLOT = 5,
  parameter int NCNT  = 2,
  parameter int VW    = 8
) (
  input  logic [NSLOT*SQ_COND_W-1:0] slots_i,
  input  logic [SQ_NEV-1:0]          evt_i,
  input  logic [NCNT*VW-1:0]         cnt_i,
  input  logic [2*VW-1:0]            ref_i,
  output logic                       hit_o,
  output logic [SQ_AW-1:0]           tgt_o
);
  localparam int CIW = (NCNT > 1) ? $clog2(NCNT) : 1;

  logic [NSLOT-1:0] truth;
  logic [NSLOT-1:0] link;
  logic [SQ_AW-1:0] tgts [NSLOT];
  logic             acc;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    cond_t         c;
    logic [VW-1:0] cv, rv;
    logic          base;
    assign c  = cond_t'(slots_i[i*SQ_COND_W +: SQ_COND_W]);
    assign cv = cnt_i[c.idx[CIW-1:0]*VW +: VW];
    assign rv = ref_i[c.rsel*VW +: VW];
    always_comb begin
      case (c.cmp)
        CMP_EVT: base = c.rsel ? 1'b1 : evt_i[c.idx];
        CMP_LT:  base = cv < rv;
        CMP_EQ:  base = cv == rv;
        default: base = cv > rv;
      endcase
    end
    assign truth[i] = base ^ c.inv;
    assign link[i]  = c.chain;
    assign tgts[i]  = c.tgt;
  end

  always_comb begin
    hit_o = 1'b0;
    tgt_o = '0;
    acc   = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      acc = acc & truth[i];
      if (!link[i] || i == NSLOT - 1) begin
        if (acc && !hit_o) begin
          hit_o = 1'b1;
          tgt_o = tgts[i];
        end
        acc = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_hist_bank.sv
module sq_hist_bank #(
  parameter int NSS = 8,
  parameter int AW  = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [$clog2(NSS)-1:0] cfg_idx_i,
  input  logic [AW-1:0]          cfg_val_i,
  input  logic                   flag_we_i,
  input  logic [NSS-1:0]         flag_val_i,
  input  logic                   sv_we_i,
  input  logic [$clog2(NSS)-1:0] sv_idx_i,
  input  logic [AW-1:0]          sv_val_i,
  output logic [NSS*AW-1:0]      hist_o,
  output logic [NSS-1:0]         flags_o
);
  for (genvar s = 0; s < NSS; s++) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        hist_o[s*AW +: AW] <= '0;
      end else if (cfg_we_i && cfg_idx_i == s) begin
        hist_o[s*AW +: AW] <= cfg_val_i;
      end else if (sv_we_i && sv_idx_i == s) begin
        hist_o[s*AW +: AW] <= sv_val_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        flags_o <= '0;
    else if (flag_we_i) flags_o <= flag_val_i;
  end
endmodule

// File: rtl/sq_sequencer.sv
module sq_sequencer import sq_pkg::*; #(
  parameter int NSS      = 8,
  parameter int NSLOT    = 5,
  parameter int NACT     = 2,
  parameter int AFW      = 6,
  parameter int NCNT     = 2,
  parameter int VW       = 8,
  parameter int START_SS = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_valid_i,
  output logic                   cfg_ready_o,
  input  logic [7:0]             cfg_data_i,
  input  logic [SQ_NEV-1:0]      evt_i,
  input  logic [NCNT*VW-1:0]     cnt_i,
  input  logic [2*VW-1:0]        ref_i,
  output logic                   run_o,
  output logic [SQ_AW-1:0]       pc_o,
  output logic [$clog2(NSS)-1:0] ss_o,
  output logic [NACT*AFW-1:0]    act_o
);
  localparam int AW    = SQ_AW;
  localparam int DEPTH = 2 ** AW;
  localparam int CONDS = NSLOT * SQ_COND_W;
  localparam int IW    = CONDS + NACT * AFW;
  localparam int IXW   = $clog2(NSS);

  logic             done;
  logic             hist_we, flag_we, mem_we;
  logic [IXW-1:0]   hist_idx;
  logic [AW-1:0]    hist_val, mem_addr;
  logic [NSS-1:0]   flag_val, hist_flags;
  logic [IW-1:0]    mem_wdata, instr;
  logic [NSS*AW-1:0] hist_vec;
  logic             cond_hit;
  logic [AW-1:0]    cond_tgt, hist_tgt;
  logic [IXW-1:0]   tgt_idx;
  logic             to_ss, save_we;
  logic [IW-1:0]    mem [DEPTH];

  sq_cfg_loader #(.NSS(NSS), .AW(AW), .DEPTH(DEPTH), .IW(IW)) i_loader (
    .clk_i, .rst_ni,
    .valid_i(cfg_valid_i), .ready_o(cfg_ready_o), .data_i(cfg_data_i),
    .done_o(done),
    .hist_we_o(hist_we), .hist_idx_o(hist_idx), .hist_val_o(hist_val),
    .flag_we_o(flag_we), .flag_val_o(flag_val),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always_ff @(posedge clk_i) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end
  assign instr = mem[pc_o];

  sq_cond_eval #(.NSLOT(NSLOT), .NCNT(NCNT), .VW(VW)) i_cond (
    .slots_i(instr[CONDS-1:0]), .evt_i, .cnt_i, .ref_i,
    .hit_o(cond_hit), .tgt_o(cond_tgt)
  );

  assign tgt_idx  = cond_tgt[IXW-1:0];
  assign to_ss    = cond_hit && (cond_tgt < AW'(NSS));
  assign hist_tgt = hist_vec[tgt_idx*AW +: AW];
  assign save_we  = done && to_ss && hist_flags[ss_o];

  sq_hist_bank #(.NSS(NSS), .AW(AW)) i_hist (
    .clk_i, .rst_ni,
    .cfg_we_i(hist_we), .cfg_idx_i(hist_idx), .cfg_val_i(hist_val),
    .flag_we_i(flag_we), .flag_val_i(flag_val),
    .sv_we_i(save_we), .sv_idx_i(ss_o), .sv_val_i(pc_o),
    .hist_o(hist_vec), .flags_o(hist_flags)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pc_o <= '0;
      ss_o <= '0;
    end else if (!done) begin
      pc_o <= hist_vec[START_SS*AW +: AW];
      ss_o <= IXW'(START_SS);
    end else if (cond_hit) begin
      pc_o <= to_ss ? hist_tgt : cond_tgt;
      if (to_ss) ss_o <= tgt_idx;
    end
  end

  assign run_o = done;
  assign act_o = done ? instr[IW-1:CONDS] : '0;
endmodule

// File: rtl/sq_sequencer_chk.sv
module sq_sequencer_chk #(
  parameter int NSS = 8,
  parameter int AW  = 6,
  parameter int AOW = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   run,
  input logic                   ready,
  input logic [AW-1:0]          pc,
  input logic [$clog2(NSS)-1:0] ss,
  input logic [AOW-1:0]         act,
  input logic                   hit,
  input logic [AW-1:0]          tgt,
  input logic [NSS*AW-1:0]      hist,
  input logic [NSS-1:0]         flags
);
  localparam int IXW = $clog2(NSS);

  logic           is_ss;
  logic [IXW-1:0] tix, q_ss;
  logic [AW-1:0]  hist_tgt, hist_qss;

  assign is_ss    = hit && (tgt < AW'(NSS));
  assign tix      = tgt[IXW-1:0];
  assign hist_tgt = hist[tix*AW +: AW];
  assign hist_qss = hist[q_ss*AW +: AW];

  always_ff @(posedge clk_i) q_ss <= ss;

  p_act_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> act == '0);
  p_run_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> run && !ready);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !hit |=> $stable(pc));
  p_ss_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !is_ss |=> $stable(ss));
  p_translate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && is_ss && tix != ss |=> pc == $past(hist_tgt) && ss == $past(tix));
  p_save_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && is_ss && flags[ss] && tix != ss |=> hist_qss == $past(pc));
endmodule

bind sq_sequencer sq_sequencer_chk #(.NSS(NSS), .AW(SQ_AW), .AOW(NACT*AFW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run_o), .ready(cfg_ready_o),
  .pc(pc_o), .ss(ss_o), .act(act_o), .hit(cond_hit), .tgt(cond_tgt),
  .hist(hist_vec), .flags(hist_flags)
);

// File: tb/test_sq_sequencer.sv
module test_sq_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [7:0]  cfg_data = '0;
  logic [7:0]  evt = '0;
  logic [15:0] cnt = {8'd5, 8'd5};
  logic [15:0] refv = {8'd9, 8'd5};
  logic        run;
  logic [5:0]  pc;
  logic [2:0]  ss;
  logic [11:0] act;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [87:0] img [64];
  logic [5:0]  a0_m [64];
  logic [5:0]  a1_m [64];
  logic [5:0]  hinit [8];

  logic [5:0]  q_pc [$];
  logic [2:0]  q_ss [$];
  string       q_req [$];

  always #2.5 clk = ~clk;

  sq_sequencer i_sq_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready),
    .cfg_data_i(cfg_data), .evt_i(evt), .cnt_i(cnt), .ref_i(refv),
    .run_o(run), .pc_o(pc), .ss_o(ss), .act_o(act)
  );

  function automatic logic [13:0] sl(int idx, int cmp, bit inv, bit rsel, bit chain, int tgt);
    return {idx[2:0], cmp[1:0], inv, rsel, chain, tgt[5:0]};
  endfunction

  function automatic logic [13:0] never();
    return sl(0, 0, 1'b1, 1'b1, 1'b0, 0);
  endfunction

  function automatic logic [13:0] always_to(int t);
    return sl(0, 0, 1'b0, 1'b1, 1'b0, t);
  endfunction

  task automatic put(int a, logic [13:0] s0, logic [13:0] s1, logic [13:0] s2,
                     logic [13:0] s3, logic [13:0] s4, int x0, int x1);
    img[a]  = {6'd0, x1[5:0], x0[5:0], s4, s3, s2, s1, s0};
    a0_m[a] = x0[5:0];
    a1_m[a] = x1[5:0];
  endtask

  task automatic check(bit ok, string req, string what, int actual, int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // driver: applies inputs for one cycle and queues the expected state after the edge
  task automatic step(logic [7:0] ev, logic [7:0] c0, logic [7:0] c1,
                      logic [5:0] epc, logic [2:0] ess, string req);
    @(negedge clk);
    evt = ev;
    cnt = {c1, c0};
    q_pc.push_back(epc);
    q_ss.push_back(ess);
    q_req.push_back(req);
  endtask

  // monitor: compares one item just after each edge
  logic [5:0]  m_pc;
  logic [2:0]  m_ss;
  string       m_req;
  logic [11:0] m_act;
  always @(posedge clk) begin
    #1;
    if (q_pc.size() > 0) begin
      m_pc  = q_pc.pop_front();
      m_ss  = q_ss.pop_front();
      m_req = q_req.pop_front();
      m_act = {a1_m[m_pc], a0_m[m_pc]};
      check(pc == m_pc, m_req, "pc", int'(pc), int'(m_pc));
      check(ss == m_ss, m_req, "ss", int'(ss), int'(m_ss));
      check(act == m_act, {m_req, " R10"}, "act", int'(act), int'(m_act));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 64; a++) put(a, never(), never(), never(), never(), never(), 0, 0);
    for (int s = 0; s < 8; s++) hinit[s] = 6'd8;
    hinit[0] = 6'd16; hinit[1] = 6'd32; hinit[2] = 6'd40;
    // superstate 0 (history on)
    put(16, sl(0,0,0,0,0,17), sl(1,0,0,0,0,1), sl(2,0,0,0,1,0), sl(3,0,0,0,0,18),
        sl(2,0,0,0,0,19), 6'h11, 6'h05);
    put(17, sl(1,0,0,0,0,1), never(), never(), never(), never(), 6'h22, 6'h01);
    put(18, always_to(16), never(), never(), never(), never(), 6'h03, 6'h00);
    put(19, always_to(16), never(), never(), never(), never(), 6'h04, 6'h00);
    // superstate 1 (history off)
    put(32, sl(0,1,0,0,0,33), sl(1,2,0,1,0,34), sl(0,3,0,1,0,35), sl(6,0,1,0,1,0),
        sl(7,0,0,0,0,0), 6'h2A, 6'h15);
    put(33, always_to(32), never(), never(), never(), never(), 6'h06, 6'h00);
    put(34, always_to(32), never(), never(), never(), never(), 6'h07, 6'h00);
    put(35, sl(0,0,0,0,0,2), never(), never(), never(), never(), 6'h08, 6'h09);
    // superstate 2 (history off)
    put(40, sl(0,0,0,0,0,41), never(), never(), never(), never(), 6'h0A, 6'h00);
    put(41, sl(1,0,0,0,0,1), never(), never(), never(), never(), 6'h0B, 6'h0C);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(run == 1'b0, "R1", "run", int'(run), 0);
    check(cfg_ready == 1'b1, "R1", "ready", int'(cfg_ready), 1);
    check(act == '0, "R1", "act", int'(act), 0);

    // R11 stream: history bytes, flag byte, then words LSB first
    for (int s = 0; s < 8; s++) begin
      cfg_valid = 1'b1; cfg_data = {2'b00, hinit[s]};
      @(negedge clk);
    end
    cfg_data = 8'b0000_0001;
    @(negedge clk);
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 11; b++) begin
        cfg_data = img[a][b*8 +: 8];
        if (a == 63 && b == 10) begin
          check(run == 1'b0, "R1", "run before last byte", int'(run), 0);
        end
        @(negedge clk);
      end
    end
    cfg_valid = 1'b0;
    check(run == 1'b1, "R2", "run", int'(run), 1);
    check(cfg_ready == 1'b0, "R11", "ready after load", int'(cfg_ready), 0);
    check(pc == 6'd16, "R2", "start pc", int'(pc), 16);
    check(ss == 3'd0, "R2", "start ss", int'(ss), 0);

    step(8'h00, 8'd5, 8'd5, 6'd16, 3'd0, "R6 no true slot holds");
    cfg_valid = 1'b1; cfg_data = 8'hFF;
    step(8'h00, 8'd5, 8'd5, 6'd16, 3'd0, "R11 late byte ignored");
    step(8'h04, 8'd5, 8'd5, 6'd19, 3'd0, "R5 broken chain, R6 later slot");
    cfg_valid = 1'b0;
    step(8'h00, 8'd5, 8'd5, 6'd16, 3'd0, "R3 constant true");
    step(8'h0C, 8'd5, 8'd5, 6'd18, 3'd0, "R5 chain and");
    step(8'h00, 8'd5, 8'd5, 6'd16, 3'd0, "R3 constant true");
    step(8'h03, 8'd5, 8'd5, 6'd17, 3'd0, "R6 slot0 wins, R7 real jump");
    step(8'h02, 8'd5, 8'd5, 6'd32, 3'd1, "R8 enter superstate 1");
    step(8'h00, 8'd5, 8'd5, 6'd32, 3'd1, "R6 hold");
    step(8'h00, 8'd3, 8'd5, 6'd33, 3'd1, "R4 less");
    step(8'h00, 8'd5, 8'd5, 6'd32, 3'd1, "R7 return");
    step(8'h00, 8'd5, 8'd9, 6'd34, 3'd1, "R4 equal");
    step(8'h00, 8'd5, 8'd5, 6'd32, 3'd1, "R7 return");
    step(8'h00, 8'd10, 8'd5, 6'd35, 3'd1, "R4 greater");
    step(8'h01, 8'd5, 8'd5, 6'd40, 3'd2, "R8 enter superstate 2");
    step(8'h01, 8'd5, 8'd5, 6'd41, 3'd2, "R7 jump keeps ss");
    step(8'h02, 8'd5, 8'd5, 6'd32, 3'd1, "R9 no history restarts");
    step(8'hC0, 8'd5, 8'd5, 6'd32, 3'd1, "R3 inverted event blocks");
    step(8'h80, 8'd5, 8'd5, 6'd17, 3'd0, "R9 history resumes");
    step(8'h00, 8'd5, 8'd5, 6'd17, 3'd0, "R6 hold after resume");
    @(negedge clk);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule